// File: doc/BRIEF.md
# Command Packet Receive Router

This block is the receive side of one node on a chain of four processors that pass 24-bit words to each other. It takes a stream of words, one per cycle when `in_valid` is high, and reads the first word of each packet as a header. The header carries a source node, a destination node and a total word count. If the packet is addressed to this node, the block collects the three-character ASCII command and up to five argument words. It then presents them on a local delivery port with a single-cycle valid pulse. A packet addressed to any other node is passed unchanged, word by word, to the forwarding port. Executing the commands is left to the logic on the local side.

A second mode handles readout. A start strobe with a pixel count makes the block treat every incoming word as raw image data, with no parsing, until that many words have gone through. While in this mode the block still compares each word against a configured abort header. A match leaves image mode at once. Headers whose count is out of range raise a one-cycle error flag, and the block then treats the next word as a fresh header.

Top module: `cmd_pkt_router`

## Requirements
- R1: The header word holds the word count in bits 7:0, the destination node in bits 15:8 and the source node in bits 23:16. Node numbers are 0 host, 1 interface, 2 timing and 3 utility. The node's own number is the parameter `NODE_ID`, which defaults to 2.
- R2: A header whose count is below 2 or above 7 sets `hdr_err` for exactly the next cycle. It produces no forwarded or delivered word, and the word that follows it is parsed as a header.
- R3: A packet whose destination differs from `NODE_ID` is copied to `fwd_word` unchanged, header included. Every word appears one cycle after it is accepted, with `fwd_valid` high, and the copying stops after exactly `count` words.
- R4: For a packet addressed to this node, `loc_valid` pulses for one cycle, in the cycle after the last word is accepted. In that cycle the delivery fields hold the following:
  - `loc_src` is the header source.
  - `loc_cmd` is the second word.
  - `loc_nargs` is count minus 2.
  - Slot i of `loc_args` (bits 24i+23:24i) holds packet word i+3.
  - Slots beyond `loc_nargs` read zero.
- R5: A packet addressed to this node produces no `fwd_valid`, and a forwarded packet produces no `loc_valid`.
- R6: `img_start`, sampled while idle with `in_valid` low and `img_len` non-zero, enters image mode, and `img_busy` is high from the next cycle. Each accepted word then appears on `img_word`, with `img_valid` high one cycle later, and is never parsed. After `img_len` words, parsing resumes with the next word as a header.
- R7: In image mode, a word equal to `abort_hdr` ends image mode. It is not output as image data, and `img_busy` is low in the following cycle.
- R8: `img_start` is ignored while a packet is only partly received, in a cycle where `in_valid` is high, and when `img_len` is zero.
- R9: After reset, all valid and flag outputs and `img_busy` are low, and the first accepted word is parsed as a header.
- R10: A cycle with `in_valid` low changes nothing and produces no output. Gaps inside a packet or an image stream are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word present |
| in_word | input | 24 | Incoming word |
| img_start | input | 1 | Request to enter image mode |
| img_len | input | 16 | Number of image words to pass |
| abort_hdr | input | 24 | Word that ends image mode early |
| fwd_valid | output | 1 | Forwarded word present |
| fwd_word | output | 24 | Forwarded word |
| loc_valid | output | 1 | Local packet complete (one cycle) |
| loc_src | output | 8 | Source node of the local packet |
| loc_cmd | output | 24 | ASCII command word |
| loc_nargs | output | 3 | Number of arguments (0 to 5) |
| loc_args | output | 120 | Argument slots, slot 0 in the low bits |
| img_valid | output | 1 | Image word present |
| img_word | output | 24 | Image word |
| img_busy | output | 1 | Image mode active |
| hdr_err | output | 1 | Header count out of range (one cycle) |

## Verification
The bench probes both ends of the count range. Counts 0, 1 and 8 must be rejected. A wrongly bounded compare would either deliver garbage or swallow the following packets as body words. A 2-word reply must deliver zero arguments with all slots cleared, and a 7-word packet with gaps between its words must fill all five slots; an off-by-one in the word counter would pulse one word early or late, or shift the slots. In image mode, the bench sends words that look like valid headers and checks that they pass through as data. It checks that the stream ends after exactly the programmed length, that the abort word cuts it short without being emitted, and that a start strobe in the middle of a packet leaves the packet to complete normally.

// File: rtl/cmd_pkt_router.sv
module cmd_pkt_router #(
  parameter int W         = 24,
  parameter int NODE_ID   = 2,
  parameter int MAX_WORDS = 7,
  parameter int PIXW      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [W-1:0]                in_word,
  input  logic                        img_start,
  input  logic [PIXW-1:0]             img_len,
  input  logic [W-1:0]                abort_hdr,
  output logic                        fwd_valid,
  output logic [W-1:0]                fwd_word,
  output logic                        loc_valid,
  output logic [7:0]                  loc_src,
  output logic [W-1:0]                loc_cmd,
  output logic [$clog2(MAX_WORDS+1)-1:0] loc_nargs,
  output logic [(MAX_WORDS-2)*W-1:0]  loc_args,
  output logic                        img_valid,
  output logic [W-1:0]                img_word,
  output logic                        img_busy,
  output logic                        hdr_err
);
  localparam int CW   = $clog2(MAX_WORDS+1);
  localparam int NARG = MAX_WORDS - 2;

  typedef enum logic [1:0] {S_HDR, S_LOC, S_FWD, S_IMG} st_t;

  st_t             st;
  logic [CW-1:0]   left, idx, total;
  logic [PIXW-1:0] pix_left;
  logic [W-1:0]    args [NARG];

  wire [7:0] h_cnt  = in_word[7:0];
  wire [7:0] h_dst  = in_word[15:8];
  wire       h_ok   = (h_cnt >= 8'd2) && (h_cnt <= 8'(MAX_WORDS));
  wire       h_mine = (h_dst == 8'(NODE_ID));

  assign img_busy = (st == S_IMG);

  for (genvar g = 0; g < NARG; g++) begin : g_args
    assign loc_args[g*W +: W] = args[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_HDR;
      left      <= '0;
      idx       <= '0;
      total     <= '0;
      pix_left  <= '0;
      fwd_valid <= 1'b0;
      fwd_word  <= '0;
      loc_valid <= 1'b0;
      loc_src   <= '0;
      loc_cmd   <= '0;
      loc_nargs <= '0;
      img_valid <= 1'b0;
      img_word  <= '0;
      hdr_err   <= 1'b0;
      for (int i = 0; i < NARG; i++) args[i] <= '0;
    end else begin
      fwd_valid <= 1'b0;
      loc_valid <= 1'b0;
      img_valid <= 1'b0;
      hdr_err   <= 1'b0;
      unique case (st)
        S_HDR: begin
          if (in_valid) begin
            if (!h_ok) begin
              hdr_err <= 1'b1;
            end else if (h_mine) begin
              st      <= S_LOC;
              left    <= h_cnt[CW-1:0] - 1'b1;
              total   <= h_cnt[CW-1:0];
              idx     <= '0;
              loc_src <= in_word[23:16];
              for (int i = 0; i < NARG; i++) args[i] <= '0;
            end else begin
              st        <= S_FWD;
              left      <= h_cnt[CW-1:0] - 1'b1;
              fwd_valid <= 1'b1;
              fwd_word  <= in_word;
            end
          end else if (img_start && img_len != '0) begin
            st       <= S_IMG;
            pix_left <= img_len;
          end
        end
        S_LOC: begin
          if (in_valid) begin
            if (idx == '0) loc_cmd <= in_word;
            for (int i = 0; i < NARG; i++)
              if (idx == CW'(i + 1)) args[i] <= in_word;
            idx  <= idx + 1'b1;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
              st        <= S_HDR;
              loc_valid <= 1'b1;
              loc_nargs <= total - CW'(2);
            end
          end
        end
        S_FWD: begin
          if (in_valid) begin
            fwd_valid <= 1'b1;
            fwd_word  <= in_word;
            left      <= left - 1'b1;
            if (left == CW'(1)) st <= S_HDR;
          end
        end
        S_IMG: begin
          if (in_valid) begin
            if (in_word == abort_hdr) begin
              st <= S_HDR;
            end else begin
              img_valid <= 1'b1;
              img_word  <= in_word;
              pix_left  <= pix_left - 1'b1;
              if (pix_left == PIXW'(1)) st <= S_HDR;
            end
          end
        end
        default: st <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/cmd_pkt_router_chk.sv
module cmd_pkt_router_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_word,
  input logic [W-1:0] abort_hdr,
  input logic         fwd_valid,
  input logic [W-1:0] fwd_word,
  input logic         loc_valid,
  input logic         img_valid,
  input logic         img_busy,
  input logic         hdr_err
);
  a_r3_fwd_copy: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(in_valid) && fwd_word == $past(in_word)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |=> !loc_valid);

  a_r5_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, loc_valid, img_valid, hdr_err}));

  a_r6_img_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    img_valid |-> $past(img_busy));

  a_r7_abort_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (img_busy && in_valid && in_word == abort_hdr) |=> (!img_busy && !img_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(fwd_valid || loc_valid || img_valid || hdr_err));
endmodule

bind cmd_pkt_router cmd_pkt_router_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .abort_hdr(abort_hdr), .fwd_valid(fwd_valid), .fwd_word(fwd_word),
  .loc_valid(loc_valid), .img_valid(img_valid), .img_busy(img_busy),
  .hdr_err(hdr_err)
);

// File: tb/test_cmd_pkt_router.sv
`timescale 1ns/100ps
module test_cmd_pkt_router;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [23:0]  in_word = '0;
  logic         img_start = 1'b0;
  logic [15:0]  img_len = '0;
  logic [23:0]  abort_hdr = 24'h000202;
  logic         fwd_valid, loc_valid, img_valid, img_busy, hdr_err;
  logic [23:0]  fwd_word, loc_cmd, img_word;
  logic [7:0]   loc_src;
  logic [2:0]   loc_nargs;
  logic [119:0] loc_args;

  int runs = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmd_pkt_router i_cmd_pkt_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .img_start(img_start), .img_len(img_len), .abort_hdr(abort_hdr),
    .fwd_valid(fwd_valid), .fwd_word(fwd_word), .loc_valid(loc_valid),
    .loc_src(loc_src), .loc_cmd(loc_cmd), .loc_nargs(loc_nargs),
    .loc_args(loc_args), .img_valid(img_valid), .img_word(img_word),
    .img_busy(img_busy), .hdr_err(hdr_err)
  );

  // {in_valid, in_word, exp fwd_valid, exp fwd_word, exp loc_valid, exp hdr_err}
  localparam logic [51:0] VEC [16] = '{
    {1'b1, 24'h000204, 1'b0, 24'h000000, 1'b0, 1'b0},  // R1 host->timing, 4 words
    {1'b1, 24'h57524D, 1'b0, 24'h000000, 1'b0, 1'b0},
    {1'b1, 24'h400001, 1'b0, 24'h000000, 1'b0, 1'b0},
    {1'b1, 24'h000040, 1'b0, 24'h000000, 1'b1, 1'b0},  // R4 delivered
    {1'b1, 24'h000302, 1'b1, 24'h000302, 1'b0, 1'b0},  // R3 to utility
    {1'b1, 24'h534558, 1'b1, 24'h534558, 1'b0, 1'b0},
    {1'b1, 24'h000201, 1'b0, 24'h000000, 1'b0, 1'b1},  // R2 count 1
    {1'b1, 24'h000208, 1'b0, 24'h000000, 1'b0, 1'b1},  // R2 count 8
    {1'b1, 24'h000200, 1'b0, 24'h000000, 1'b0, 1'b1},  // R2 count 0
    {1'b0, 24'h000302, 1'b0, 24'h000000, 1'b0, 1'b0},  // R10 idle
    {1'b1, 24'h030202, 1'b0, 24'h000000, 1'b0, 1'b0},  // R5 local, no fwd
    {1'b1, 24'h434C52, 1'b0, 24'h000000, 1'b1, 1'b0},
    {1'b1, 24'h020103, 1'b1, 24'h020103, 1'b0, 1'b0},  // R3 to interface
    {1'b1, 24'h000001, 1'b1, 24'h000001, 1'b0, 1'b0},
    {1'b1, 24'h000002, 1'b1, 24'h000002, 1'b0, 1'b0},
    {1'b1, 24'h010300, 1'b0, 24'h000000, 1'b0, 1'b1}   // R3 stopped at count
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [23:0] w, input bit st);
    @(negedge clk);
    in_valid  = v;
    in_word   = w;
    img_start = st;
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    img_start = 1'b0;
  endtask

  function automatic logic [3:0] flags();
    return {fwd_valid, loc_valid, img_valid, hdr_err};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset outputs", {flags(), img_busy}, 5'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][51], VEC[i][50:27], 1'b0);
      chk($sformatf("R1/R2/R3/R5 vector %0d", i),
          {fwd_valid, fwd_valid ? fwd_word : 24'h0, loc_valid, hdr_err},
          {VEC[i][26], VEC[i][25:2], VEC[i][1], VEC[i][0]});
    end

    // R4 seven-word packet with gaps (R10)
    step(1'b1, 24'h010207, 1'b0);
    step(1'b1, 24'h524443, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      step(1'b0, 24'h0, 1'b0);
      chk("R10 gap quiet", flags(), 4'b0);
      step(1'b1, 24'(k * 24'h11), 1'b0);
    end
    chk("R4 full packet", {loc_valid, loc_src, loc_cmd, 5'(loc_nargs)},
        {1'b1, 8'h01, 24'h524443, 5'd5});
    chk("R4 args", loc_args, {8'h0, 24'h000055, 24'h000044, 24'h000033, 24'h000022, 24'h000011});
    step(1'b0, 24'h0, 1'b0);
    chk("R4 one pulse", loc_valid, 1'b0);

    // R4 two-word reply
    step(1'b1, 24'h030202, 1'b0);
    step(1'b1, 24'h444F4E, 1'b0);
    chk("R4 reply", {loc_valid, loc_src, loc_cmd, 5'(loc_nargs)},
        {1'b1, 8'h03, 24'h444F4E, 5'd0});
    chk("R4 unused slots zero", loc_args, 128'h0);

    // R6 image mode, length 3
    img_len = 16'd3;
    step(1'b0, 24'h0, 1'b1);
    chk("R6 busy", img_busy, 1'b1);
    step(1'b1, 24'h000204, 1'b0);
    chk("R6 header-like word is data", {flags(), img_word}, {4'b0010, 24'h000204});
    step(1'b1, 24'hABCDEF, 1'b0);
    step(1'b1, 24'h123456, 1'b0);
    chk("R6 last word", {flags(), img_word, img_busy}, {4'b0010, 24'h123456, 1'b0});
    step(1'b1, 24'h000302, 1'b0);
    chk("R6 parsing resumes", {fwd_valid, fwd_word}, {1'b1, 24'h000302});
    step(1'b1, 24'h414243, 1'b0);

    // R7 abort
    img_len = 16'd10;
    step(1'b0, 24'h0, 1'b1);
    step(1'b1, 24'h000111, 1'b0);
    chk("R7 before abort", {img_valid, img_word}, {1'b1, 24'h000111});
    step(1'b1, 24'h000202, 1'b0);
    chk("R7 abort exit", {img_valid, img_busy}, 2'b00);
    step(1'b1, 24'h010302, 1'b0);
    chk("R7 header after abort", {fwd_valid, fwd_word}, {1'b1, 24'h010302});
    step(1'b1, 24'h444F4E, 1'b0);

    // R8 ignored starts
    img_len = 16'd0;
    step(1'b0, 24'h0, 1'b1);
    chk("R8 zero length", img_busy, 1'b0);
    img_len = 16'd4;
    step(1'b1, 24'h000203, 1'b1);
    chk("R8 start with word", img_busy, 1'b0);
    step(1'b0, 24'h0, 1'b1);
    chk("R8 mid packet", img_busy, 1'b0);
    step(1'b1, 24'h535450, 1'b0);
    step(1'b1, 24'h000009, 1'b0);
    chk("R8 packet intact", {loc_valid, loc_cmd, loc_args[23:0], img_valid},
        {1'b1, 24'h535450, 24'h000009, 1'b0});

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      runs++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule